// File: doc/BRIEF.md
# Serial Port Frame Flow Control

This block sits between the transmit and receive shift engines of a serial port and the two flow-control pins. It adds frame-level handshaking to the port. When handshaking is on, the transmit side waits for the far end to pull the active-low clear-to-send pin low before it grants the next frame. The receive side raises the active-low request-to-send pin after every complete frame, which asks the far end to pause. The pin drops again when the receiver reports that it can take more data.

The transmit decision is made only at frame boundaries. A frame that has already been granted always runs to its end. Only the grant of the following frame waits for clear-to-send. Meanwhile the data refill request to the CPU or DMA side keeps tracking the transmit buffer, so the next word is fetched while the line is paused. When the handshake enable is low, clear-to-send has no effect and request-to-send stays low.

Top module: `uart_frame_flowctl`

## Requirements
- R1: After synchronous reset, `rts_n` is 0, `tx_frame_start` is 0, `tx_halted` is 0 and `tx_refill_req` is 0.
- R2: With `hs_en` = 0, a pending `tx_frame_req` is granted whatever level `cts_n` has.
- R3: With `hs_en` = 0, `rts_n` is 0 from the next cycle on, and `rx_frame_rcvd` has no effect on it.
- R4: With `hs_en` = 1 and the synchronised `cts_n` low, an idle transmitter that sees `tx_frame_req` drives `tx_frame_start` high for exactly one cycle, on the edge after the request is sampled.
- R5: With `hs_en` = 1 and the synchronised `cts_n` high, no frame is granted, and `tx_halted` is 1 while a request is pending in the idle state.
- R6: A frame in progress is unaffected by `cts_n`. There is one grant per frame, and the next grant waits for `tx_frame_done`. `tx_halted` stays 0 while a frame is in progress.
- R7: `cts_n` passes through `SYNC_STAGES` flip-flops. When `cts_n` falls while a request is held off, `tx_frame_start` rises on the (`SYNC_STAGES`+1)-th rising clock edge after the change.
- R8: `tx_refill_req` equals `tx_buf_empty` one cycle later, including while the transmitter is halted.
- R9: With `hs_en` = 1, a `rx_frame_rcvd` pulse sets `rts_n` to 1 on the next edge, and it holds there until readiness is signalled.
- R10: With `hs_en` = 1, a one-cycle `rx_ready` pulse returns `rts_n` to 0 on the next edge.
- R11: When `rx_frame_rcvd` and `rx_ready` arrive in the same cycle, `rts_n` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_en | input | 1 | Handshake enable from the line mode register |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_frame_req | input | 1 | Transmit shifter wants to start a frame (held until granted) |
| tx_frame_done | input | 1 | Transmit shifter finished the current frame (pulse) |
| tx_buf_empty | input | 1 | Transmit holding buffer needs new data |
| tx_frame_start | output | 1 | One-cycle grant to start a frame |
| tx_halted | output | 1 | Pending request held off by clear-to-send |
| tx_refill_req | output | 1 | Data request to interrupt or DMA logic |
| rx_frame_rcvd | input | 1 | Receiver completed a frame (pulse) |
| rx_ready | input | 1 | Receiver ready for more data (pulse) |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2. The exact grant latency after a clear-to-send release therefore shows whether the chain length really follows the parameter, and is not fixed at two flops. The three-stage chain also puts a window of several cycles between a pin change and its effect. That window lets the bench drop clear-to-send in the middle of a frame and confirm that the frame carries on, and that only the next grant is held.

// File: rtl/uart_flowctl_pkg.sv
package uart_flowctl_pkg;

  typedef enum logic {
    TXG_IDLE   = 1'b0,
    TXG_ACTIVE = 1'b1
  } txg_state_e;

endpackage

// File: rtl/flowctl_cts_sync.sv
module flowctl_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= pin_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[LAST-1:0], pin_n};
      end
    end
  endgenerate

  assign sync_n = chain[LAST];

endmodule

// File: rtl/flowctl_tx_gate.sv
module flowctl_tx_gate
  import uart_flowctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hs_en,
  input  logic cts_sync_n,
  input  logic frame_req,
  input  logic frame_done,
  input  logic buf_empty,
  output logic frame_start,
  output logic halted,
  output logic refill_req
);

  txg_state_e state;
  logic       line_clear;

  assign line_clear = !hs_en || !cts_sync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TXG_IDLE;
      frame_start <= 1'b0;
      halted      <= 1'b0;
      refill_req  <= 1'b0;
    end else begin
      refill_req  <= buf_empty;
      frame_start <= 1'b0;
      halted      <= 1'b0;
      unique case (state)
        TXG_IDLE: begin
          if (frame_req) begin
            if (line_clear) begin
              state       <= TXG_ACTIVE;
              frame_start <= 1'b1;
            end else begin
              halted <= 1'b1;
            end
          end
        end
        TXG_ACTIVE: begin
          if (frame_done) state <= TXG_IDLE;
        end
        default: state <= TXG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flowctl_rts_ctl.sv
module flowctl_rts_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hs_en,
  input  logic frame_rcvd,
  input  logic ready,
  output logic rts_n
);

  always_ff @(posedge clk) begin
    if (rst)             rts_n <= 1'b0;
    else if (!hs_en)     rts_n <= 1'b0;
    else if (frame_rcvd) rts_n <= 1'b1;
    else if (ready)      rts_n <= 1'b0;
  end

endmodule

// File: rtl/uart_frame_flowctl.sv
module uart_frame_flowctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_en,
  input  logic cts_n,
  input  logic tx_frame_req,
  input  logic tx_frame_done,
  input  logic tx_buf_empty,
  output logic tx_frame_start,
  output logic tx_halted,
  output logic tx_refill_req,
  input  logic rx_frame_rcvd,
  input  logic rx_ready,
  output logic rts_n
);

  logic cts_sync_n;

  flowctl_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (cts_n),
    .sync_n (cts_sync_n)
  );

  flowctl_tx_gate u_txg (
    .clk         (clk),
    .rst         (rst),
    .hs_en       (hs_en),
    .cts_sync_n  (cts_sync_n),
    .frame_req   (tx_frame_req),
    .frame_done  (tx_frame_done),
    .buf_empty   (tx_buf_empty),
    .frame_start (tx_frame_start),
    .halted      (tx_halted),
    .refill_req  (tx_refill_req)
  );

  flowctl_rts_ctl u_rts (
    .clk        (clk),
    .rst        (rst),
    .hs_en      (hs_en),
    .frame_rcvd (rx_frame_rcvd),
    .ready      (rx_ready),
    .rts_n      (rts_n)
  );

endmodule

// File: rtl/uart_frame_flowctl_chk.sv
module uart_frame_flowctl_chk (
  input logic clk,
  input logic rst,
  input logic hs_en,
  input logic cts_sync_n,
  input logic tx_buf_empty,
  input logic tx_frame_start,
  input logic tx_halted,
  input logic tx_refill_req,
  input logic rx_frame_rcvd,
  input logic rx_ready,
  input logic rts_n
);

  // R3
  rts_low_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_en |=> !rts_n);

  // R9
  rts_high_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    hs_en && rx_frame_rcvd |=> rts_n);

  // R10
  rts_low_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    hs_en && rx_ready && !rx_frame_rcvd |=> !rts_n);

  // R8
  refill_follows_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_refill_req == $past(tx_buf_empty));

  // R4
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_frame_start |=> !tx_frame_start);

  // R5
  no_start_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    hs_en && cts_sync_n |=> !tx_frame_start);

  // R5
  start_halt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_frame_start && tx_halted));

  // R6
  no_halt_right_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    tx_frame_start |=> !tx_halted);

endmodule

bind uart_frame_flowctl uart_frame_flowctl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .hs_en          (hs_en),
  .cts_sync_n     (cts_sync_n),
  .tx_buf_empty   (tx_buf_empty),
  .tx_frame_start (tx_frame_start),
  .tx_halted      (tx_halted),
  .tx_refill_req  (tx_refill_req),
  .rx_frame_rcvd  (rx_frame_rcvd),
  .rx_ready       (rx_ready),
  .rts_n          (rts_n)
);

// File: tb/tb_uart_frame_flowctl.sv
module tb_uart_frame_flowctl;

  localparam int SYNC = 3;
  localparam int NVEC = 9;

  // {hs_en, cts_n, rx_frame_rcvd, rx_ready, exp_start, exp_halted, exp_rts_n}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_0_1_0_1_0_0,  // R2 R3
    7'b0_1_0_0_1_0_0,  // R2
    7'b1_0_1_0_1_0_1,  // R4 R9
    7'b1_1_0_0_0_1_1,  // R5 R9 hold
    7'b1_1_0_1_0_1_0,  // R5 R10
    7'b1_0_1_1_1_0_1,  // R11
    7'b1_0_0_1_1_0_0,  // R10
    7'b1_0_1_0_1_0_1,  // R9
    7'b0_1_0_0_1_0_0   // R3 clears
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_en = 1'b0, cts_n = 1'b0, tx_frame_req = 1'b0, tx_frame_done = 1'b0;
  logic tx_buf_empty = 1'b0, rx_frame_rcvd = 1'b0, rx_ready = 1'b0;
  logic tx_frame_start, tx_halted, tx_refill_req, rts_n;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_frame_flowctl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .hs_en(hs_en), .cts_n(cts_n),
    .tx_frame_req(tx_frame_req), .tx_frame_done(tx_frame_done),
    .tx_buf_empty(tx_buf_empty), .tx_frame_start(tx_frame_start),
    .tx_halted(tx_halted), .tx_refill_req(tx_refill_req),
    .rx_frame_rcvd(rx_frame_rcvd), .rx_ready(rx_ready), .rts_n(rts_n)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int starts;
    int first_k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rts_n", rts_n, 1'b0);
    check("R1 start", tx_frame_start, 1'b0);
    check("R1 halted", tx_halted, 1'b0);
    check("R1 refill", tx_refill_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      hs_en = VEC[v][6];
      cts_n = VEC[v][5];
      tx_frame_req = 1'b0;
      @(negedge clk);
      rx_frame_rcvd = VEC[v][4];
      rx_ready = VEC[v][3];
      @(negedge clk);
      rx_frame_rcvd = 1'b0;
      rx_ready = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
      tx_frame_req = 1'b1;
      starts = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (tx_frame_start) starts++;
      end
      check($sformatf("R2/R4/R5 vec%0d start", v), starts > 0, VEC[v][2]);
      check($sformatf("R5 vec%0d halted", v), tx_halted, VEC[v][1]);
      check($sformatf("R3/R9/R10/R11 vec%0d rts_n", v), rts_n, VEC[v][0]);
      tx_frame_req = 1'b0;
      if (starts > 0) begin
        tx_frame_done = 1'b1;
        @(negedge clk);
        tx_frame_done = 1'b0;
      end
      repeat (2) @(negedge clk);
    end

    // R6: clear-to-send raised mid-frame, request kept high
    hs_en = 1'b1;
    cts_n = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    tx_frame_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 grant", tx_frame_start, 1'b0);
    cts_n = 1'b1;
    starts = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (tx_frame_start) starts++;
    end
    check("R6 no second grant in frame", starts != 0, 1'b0);
    check("R6 not halted in frame", tx_halted, 1'b0);
    tx_frame_done = 1'b1;
    @(negedge clk);
    tx_frame_done = 1'b0;
    tx_buf_empty = 1'b1;
    starts = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (tx_frame_start) starts++;
    end
    check("R6 held after done", starts != 0, 1'b0);
    check("R5 halted after done", tx_halted, 1'b1);
    check("R8 refill while halted", tx_refill_req, 1'b1);
    tx_buf_empty = 1'b0;
    @(negedge clk);
    check("R8 refill drops", tx_refill_req, 1'b0);

    // R7 release latency
    cts_n = 1'b0;
    first_k = 0;
    for (int k = 1; k <= SYNC + 4; k++) begin
      @(negedge clk);
      if (tx_frame_start && first_k == 0) first_k = k;
    end
    checks++;
    if (first_k != SYNC + 1) begin
      fails++;
      $display("FAIL R7 latency actual=%0d expected=%0d", first_k, SYNC + 1);
    end
    tx_frame_req = 1'b0;
    tx_frame_done = 1'b1;
    @(negedge clk);
    tx_frame_done = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule